// File: doc/BRIEF.md
# PHY discovery and setup sequencer

This block brings up an Ethernet PHY without software involvement. After a one-cycle start pulse it walks the management-bus address space looking for a device. A device counts as present when both of its first two registers read back cleanly and they are not both all-ones. It then resets the device and waits for the reset to finish. Next it collects the 32-bit identifier. Last, it advertises 10/100 capabilities and restarts auto-negotiation.

The block does not produce the serial management framing. It drives a separate management master through a request/response port. A request is a one-cycle pulse that carries the operation, the PHY address, the register number and the write data. The master answers with a one-cycle done pulse that carries read data and an error flag. Only one request is outstanding at a time. When the sequence ends, busy falls and the result is visible on found, fail, phy_addr and phy_id.

Top module: `phy_setup_seq`

## Requirements
- R1: After start, the scan visits addresses 0, 1, 2, ... in increasing order. At each address it reads register 0 and then register 1.
- R2: An address is taken as the PHY only when neither scan read reports mgmt_err and the two values are not both 16'hFFFF. The scan stops at the first such address, and that address appears on phy_addr.
- R3: If none of the 2**ADDR_W addresses qualifies, the run ends after exactly two reads per address. It ends with fail=1 and found=0, and issues no further requests.
- R4: For the found PHY, the sequencer writes 16'h8000 (reset, bit 15) to register 0. It then reads register 0 repeatedly until bit 15 reads 0, issuing at most POLL_MAX such reads.
- R5: A reset failure ends the run with found=0 and fail=1 and issues no further requests. A reset failure is any of: mgmt_err on the reset write, mgmt_err on a poll read, or bit 15 still set on the POLL_MAX-th read.
- R6: After the reset completes, the sequencer reads register 2 and then register 3. phy_id = (reg2 << 16) | reg3.
- R7: Next, it reads register 0 and writes back that value with bit 12 (auto-negotiation enable) cleared.
- R8: Next, it reads register 4 and writes back that value with bits 8, 7 and 5 set (100 full, 100 half and 10 capability).
- R9: Last, it writes register 0 with bit 12 set, and then writes it again with bits 12 and 9 (restart) both set. These are two separate writes. The run then ends with found=1 and fail=0.
- R10: mgmt_req is a single-cycle pulse. No new request is issued until mgmt_done has answered the previous one. No request is issued while idle.
- R11: busy rises in the cycle after an accepted start and stays high until the run ends. A start pulse that arrives while busy has no effect on the request sequence.
- R12: Out of reset, busy, found, fail, mgmt_req, phy_addr and phy_id are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins discovery |
| busy | output | 1 | High while a run is in progress |
| found | output | 1 | PHY found and configured |
| fail | output | 1 | Run ended without a usable PHY |
| phy_addr | output | ADDR_W | Address of the found PHY |
| phy_id | output | 32 | Identifier assembled from registers 2 and 3 |
| mgmt_req | output | 1 | Request pulse to the management master |
| mgmt_we | output | 1 | 1 = write, 0 = read |
| mgmt_phy | output | ADDR_W | PHY address of the request |
| mgmt_reg | output | 5 | Register number of the request |
| mgmt_wdata | output | 16 | Write data |
| mgmt_done | input | 1 | Response pulse from the master |
| mgmt_rdata | input | 16 | Read data, valid with mgmt_done |
| mgmt_err | input | 1 | Bus error, valid with mgmt_done |

## Verification
The bench builds the block with ADDR_W=5 so that the full 32-address scan is exercised, including a find at the last address and a scan that finds nothing. POLL_MAX is set to 4. This lets a run reach the reset-timeout failure within a few polls, and lets another run clear the reset on exactly the last permitted poll. A behavioural PHY model with adjustable response latency answers every request. Each request is compared with a sequence that the bench derives from the requirements.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int REG_W = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN_CR, S_SCAN_SR, S_RST, S_POLL, S_ID_HI, S_ID_LO,
    S_AN_RD, S_AN_CLR, S_ADV_RD, S_ADV_WR, S_AN_EN, S_AN_RST
  } step_t;

  localparam logic [4:0] REG_CTRL  = 5'd0;
  localparam logic [4:0] REG_STAT  = 5'd1;
  localparam logic [4:0] REG_ID_HI = 5'd2;
  localparam logic [4:0] REG_ID_LO = 5'd3;
  localparam logic [4:0] REG_ADV   = 5'd4;

  localparam int BIT_RESET   = 15;
  localparam int BIT_AN_EN   = 12;
  localparam int BIT_RESTART = 9;
  localparam logic [REG_W-1:0] ADV_CAPS = 16'h01A0;

  // device presence test on the two scan reads
  function automatic logic phy_present(input logic [REG_W-1:0] cr, input logic cr_err,
                                       input logic [REG_W-1:0] sr, input logic sr_err);
    return !cr_err && !sr_err && !((cr == '1) && (sr == '1));
  endfunction

  function automatic logic [REG_W-1:0] ctrl_an_off(input logic [REG_W-1:0] cr);
    return cr & ~(REG_W'(1) << BIT_AN_EN);
  endfunction

  function automatic logic [REG_W-1:0] ctrl_an_on(input logic [REG_W-1:0] cr);
    return ctrl_an_off(cr) | (REG_W'(1) << BIT_AN_EN);
  endfunction

  function automatic logic [REG_W-1:0] ctrl_an_restart(input logic [REG_W-1:0] cr);
    return ctrl_an_on(cr) | (REG_W'(1) << BIT_RESTART);
  endfunction
endpackage

// File: rtl/phy_seq_addr_ctr.sv
module phy_seq_addr_ctr #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)     addr <= '0;
    else if (clr)   addr <= '0;
    else if (inc)   addr <= addr + 1'b1;
  end

  assign last = (addr == LAST_ADDR);

  // R1: scan moves to the next address, one at a time
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (addr == ADDR_W'($past(addr) + 1'b1)));
  a_r1_addr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0));
endmodule

// File: rtl/phy_seq_poll_ctr.sv
module phy_seq_poll_ctr #(
  parameter int POLL_MAX = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            inc,
  output logic [$clog2(POLL_MAX+1)-1:0]   cnt,
  output logic                            expired
);
  localparam int CNT_W = $clog2(POLL_MAX+1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(POLL_MAX - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT);

  // R4: never more than POLL_MAX poll reads
  a_r4_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);
endmodule

// File: rtl/phy_setup_seq.sv
module phy_setup_seq
  import phy_seq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int POLL_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              found,
  output logic              fail,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [31:0]       phy_id,
  output logic              mgmt_req,
  output logic              mgmt_we,
  output logic [ADDR_W-1:0] mgmt_phy,
  output logic [4:0]        mgmt_reg,
  output logic [REG_W-1:0]  mgmt_wdata,
  input  logic              mgmt_done,
  input  logic [REG_W-1:0]  mgmt_rdata,
  input  logic              mgmt_err
);
  localparam int CNT_W = $clog2(POLL_MAX+1);

  step_t            step;
  logic             pend;
  logic [REG_W-1:0] cr_q, adv_q;
  logic             cr_err_q;

  logic [ADDR_W-1:0] addr;
  logic              addr_last, addr_clr, addr_inc;
  logic [CNT_W-1:0]  poll_cnt;
  logic              poll_expired, poll_clr, poll_inc;

  // named internal events
  logic kick, resp, scan_hit, scan_miss_end, rst_ok, rst_fail;
  assign kick          = (step == S_IDLE) && start;
  assign resp          = pend && mgmt_done;
  assign scan_hit      = resp && (step == S_SCAN_SR) &&
                         phy_present(cr_q, cr_err_q, mgmt_rdata, mgmt_err);
  assign scan_miss_end = resp && (step == S_SCAN_SR) && !scan_hit && addr_last;
  assign rst_ok        = resp && (step == S_POLL) && !mgmt_err && !mgmt_rdata[BIT_RESET];
  assign rst_fail      = resp && (((step == S_RST) && mgmt_err) ||
                         ((step == S_POLL) && (mgmt_err || (mgmt_rdata[BIT_RESET] && poll_expired))));

  assign addr_clr = kick;
  assign addr_inc = resp && (step == S_SCAN_SR) && !scan_hit && !addr_last;
  assign poll_clr = resp && (step == S_RST);
  assign poll_inc = resp && (step == S_POLL) && !mgmt_err && mgmt_rdata[BIT_RESET] && !poll_expired;

  phy_seq_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
    .addr(addr), .last(addr_last));

  phy_seq_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc),
    .cnt(poll_cnt), .expired(poll_expired));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= S_IDLE; pend <= 1'b0; found <= 1'b0; fail <= 1'b0;
      phy_id <= '0; cr_q <= '0; adv_q <= '0; cr_err_q <= 1'b0;
    end else if (step == S_IDLE) begin
      if (start) begin
        step <= S_SCAN_CR; pend <= 1'b0;
        found <= 1'b0; fail <= 1'b0; phy_id <= '0;
      end
    end else if (!pend) begin
      pend <= 1'b1;                      // request leaves this cycle
    end else if (mgmt_done) begin
      pend <= 1'b0;
      unique case (step)
        S_SCAN_CR: begin cr_q <= mgmt_rdata; cr_err_q <= mgmt_err; step <= S_SCAN_SR; end
        S_SCAN_SR: begin
          if (scan_hit)           begin found <= 1'b1; step <= S_RST; end
          else if (scan_miss_end) begin fail <= 1'b1;  step <= S_IDLE; end
          else                    step <= S_SCAN_CR;
        end
        S_RST:     step <= rst_fail ? S_IDLE : S_POLL;
        S_POLL:    if (rst_ok) step <= S_ID_HI;
                   else if (rst_fail) step <= S_IDLE;
        S_ID_HI:   begin phy_id[31:16] <= mgmt_rdata; step <= S_ID_LO; end
        S_ID_LO:   begin phy_id[15:0]  <= mgmt_rdata; step <= S_AN_RD; end
        S_AN_RD:   begin cr_q <= mgmt_rdata; step <= S_AN_CLR; end
        S_AN_CLR:  step <= S_ADV_RD;
        S_ADV_RD:  begin adv_q <= mgmt_rdata; step <= S_ADV_WR; end
        S_ADV_WR:  step <= S_AN_EN;
        S_AN_EN:   step <= S_AN_RST;
        default:   step <= S_IDLE;
      endcase
      if (rst_fail) begin found <= 1'b0; fail <= 1'b1; end
    end
  end

  // request fields per step
  always_comb begin
    mgmt_we = 1'b0; mgmt_reg = REG_CTRL; mgmt_wdata = '0;
    unique case (step)
      S_SCAN_SR: mgmt_reg = REG_STAT;
      S_RST:     begin mgmt_we = 1'b1; mgmt_wdata = REG_W'(1) << BIT_RESET; end
      S_ID_HI:   mgmt_reg = REG_ID_HI;
      S_ID_LO:   mgmt_reg = REG_ID_LO;
      S_AN_CLR:  begin mgmt_we = 1'b1; mgmt_wdata = ctrl_an_off(cr_q); end
      S_ADV_RD:  mgmt_reg = REG_ADV;
      S_ADV_WR:  begin mgmt_we = 1'b1; mgmt_reg = REG_ADV; mgmt_wdata = adv_q | ADV_CAPS; end
      S_AN_EN:   begin mgmt_we = 1'b1; mgmt_wdata = ctrl_an_on(cr_q); end
      S_AN_RST:  begin mgmt_we = 1'b1; mgmt_wdata = ctrl_an_restart(cr_q); end
      default:   ;
    endcase
  end

  assign busy     = (step != S_IDLE);
  assign mgmt_req = busy && !pend;
  assign mgmt_phy = addr;
  assign phy_addr = addr;

  // R10: single-cycle request, never while idle
  a_r10_one_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req |=> !mgmt_req);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mgmt_req);
  // R9: restart is only ever written together with enable
  a_r9_restart_with_en: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_we && (mgmt_reg == REG_CTRL) && mgmt_wdata[BIT_RESTART])
      |-> mgmt_wdata[BIT_AN_EN]);
  // R3: a finished run reports exactly one outcome
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (found != fail));
  // R5: failure never coexists with found
  a_r5_fail_not_found: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !found);
  // R2: a qualifying scan response marks the PHY as found
  a_r2_hit_sets_found: assert property (@(posedge clk) disable iff (!rst_n)
    scan_hit |=> (found && busy));
endmodule

// File: tb/phy_setup_seq_test.sv
`timescale 1ns/1ps
module phy_setup_seq_test;
  localparam int AW = 5;
  localparam int PM = 4;
  localparam int K_NONE = 0, K_ERR = 1, K_PHY = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, found, fail, mgmt_req, mgmt_we;
  logic [AW-1:0] phy_addr, mgmt_phy;
  logic [31:0] phy_id;
  logic [4:0] mgmt_reg;
  logic [15:0] mgmt_wdata;
  logic mgmt_done = 1'b0, mgmt_err = 1'b0;
  logic [15:0] mgmt_rdata = '0;

  always #2 clk = ~clk;

  phy_setup_seq #(.ADDR_W(AW), .POLL_MAX(PM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .found(found),
    .fail(fail), .phy_addr(phy_addr), .phy_id(phy_id), .mgmt_req(mgmt_req),
    .mgmt_we(mgmt_we), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
    .mgmt_wdata(mgmt_wdata), .mgmt_done(mgmt_done), .mgmt_rdata(mgmt_rdata),
    .mgmt_err(mgmt_err));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scenario / PHY model state
  int kind [32];
  int pa, rst_polls, lat, rst_left;
  bit rst_err;
  logic [15:0] scan_cr, sr_v, cr_def, id_hi, id_lo, adv_def, m_r0, m_adv;

  // expected request stream
  int q_we[$], q_phy[$], q_reg[$], q_dat[$];
  string q_tag[$];
  bit exp_found, exp_fail;

  task automatic push(input int we, input int a, input int r, input int d, input string t);
    q_we.push_back(we); q_phy.push_back(a); q_reg.push_back(r);
    q_dat.push_back(d); q_tag.push_back(t);
  endtask

  task automatic gen_expect();
    int hit = -1;
    q_we.delete(); q_phy.delete(); q_reg.delete(); q_dat.delete(); q_tag.delete();
    for (int a = 0; a < 32; a++) begin
      push(0, a, 0, 0, "R1"); push(0, a, 1, 0, "R1");
      if (kind[a] == K_PHY && !(scan_cr == 16'hFFFF && sr_v == 16'hFFFF)) begin hit = a; break; end
    end
    if (hit < 0) begin exp_found = 0; exp_fail = 1; return; end
    push(1, hit, 0, 16'h8000, "R4");
    if (rst_err) begin exp_found = 0; exp_fail = 1; return; end
    for (int i = 0; i < ((rst_polls >= PM) ? PM : rst_polls + 1); i++) push(0, hit, 0, 0, "R4");
    if (rst_polls >= PM) begin exp_found = 0; exp_fail = 1; return; end
    push(0, hit, 2, 0, "R6"); push(0, hit, 3, 0, "R6");
    push(0, hit, 0, 0, "R7"); push(1, hit, 0, int'(cr_def & 16'hEFFF), "R7");
    push(0, hit, 4, 0, "R8"); push(1, hit, 4, int'(adv_def | 16'h01A0), "R8");
    push(1, hit, 0, int'(cr_def | 16'h1000), "R9");
    push(1, hit, 0, int'(cr_def | 16'h1200), "R9");
    exp_found = 1; exp_fail = 0;
  endtask

  // PHY model and response driver, all on the falling edge
  initial begin
    int cnt = 0;
    logic [15:0] rd;
    logic er;
    forever begin
      @(negedge clk);
      mgmt_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin mgmt_done = 1'b1; mgmt_rdata = rd; mgmt_err = er; end
      end
      if (mgmt_req) begin
        if (q_we.size() == 0) chk(0, "R10 unexpected request", {mgmt_we, mgmt_reg}, 0);
        else begin
          chk(mgmt_we == q_we[0][0] && mgmt_phy == q_phy[0][AW-1:0] &&
              mgmt_reg == q_reg[0][4:0] && (!mgmt_we || mgmt_wdata == q_dat[0][15:0]),
              q_tag[0], {mgmt_we, mgmt_phy, mgmt_reg, mgmt_wdata},
              {q_we[0][0], q_phy[0][4:0], q_reg[0][4:0], q_dat[0][15:0]});
          void'(q_we.pop_front()); void'(q_phy.pop_front()); void'(q_reg.pop_front());
          void'(q_dat.pop_front()); void'(q_tag.pop_front());
        end
        rd = 16'hFFFF; er = 1'b0;
        if (kind[mgmt_phy] == K_ERR) begin rd = 16'h0000; er = (mgmt_reg == 0); end
        else if (kind[mgmt_phy] == K_PHY) begin
          if (mgmt_we) begin
            rd = 16'h0000;
            if (mgmt_reg == 0) begin
              if (mgmt_wdata[15]) begin m_r0 = cr_def; rst_left = rst_polls; er = rst_err; end
              else m_r0 = mgmt_wdata;
            end else if (mgmt_reg == 4) m_adv = mgmt_wdata;
          end else case (mgmt_reg)
            0: begin rd = m_r0; if (rst_left > 0) begin rst_left--; rd = m_r0 | 16'h8000; end end
            1: rd = sr_v;
            2: rd = id_hi;
            3: rd = id_lo;
            4: rd = m_adv;
            default: rd = 16'h0000;
          endcase
        end
        cnt = lat;
      end
    end
  end

  task automatic setup(input int p, input logic [15:0] scr, input logic [15:0] srv,
                       input logic [15:0] cdef, input logic [15:0] ih, input logic [15:0] il,
                       input logic [15:0] adv, input int polls, input bit rerr, input int l);
    for (int a = 0; a < 32; a++) kind[a] = K_NONE;
    pa = p; if (p >= 0) kind[p] = K_PHY;
    scan_cr = scr; sr_v = srv; cr_def = cdef; id_hi = ih; id_lo = il; adv_def = adv;
    rst_polls = polls; rst_err = rerr; lat = l;
    m_r0 = scr; m_adv = adv; rst_left = 0;
  endtask

  task automatic run(input string name, input bit restart_mid);
    int t = 0;
    gen_expect();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, {"R11 busy after start ", name}, busy, 1);
    if (restart_mid) begin
      repeat (25) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk(!busy, {"R11 run ends ", name}, busy, 0);
    repeat (6) @(negedge clk);
    chk(q_we.size() == 0, {"R10 all requests issued ", name}, q_we.size(), 0);
    chk(found == exp_found, {"R2 R3 R5 found ", name}, found, exp_found);
    chk(fail == exp_fail, {"R3 R5 fail ", name}, fail, exp_fail);
    chk(!mgmt_req && !busy, {"R10 quiet after end ", name}, mgmt_req, 0);
    if (exp_found) begin
      chk(phy_addr == pa[AW-1:0], {"R2 phy_addr ", name}, phy_addr, pa);
      chk(phy_id == {id_hi, id_lo}, {"R6 phy_id ", name}, phy_id, {id_hi, id_lo});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !found && !fail && !mgmt_req && phy_id == 0 && phy_addr == 0,
        "R12 reset state", {busy, found, fail, mgmt_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mgmt_req, "R12 idle after reset", {busy, mgmt_req}, 0);
    // R1 R2: empty, error and all-ones addresses skipped; second start ignored (R11)
    for (int a = 0; a < 32; a++) kind[a] = K_NONE;
    setup(5, 16'h3100, 16'h786D, 16'h1140, 16'h0020, 16'h6051, 16'h0001, 2, 0, 2);
    kind[3] = K_ERR;
    run("find at 5", 1);
    // R3: nothing answers
    setup(-1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    run("empty bus", 0);
    // R5: reset never completes
    setup(0, 16'h1000, 16'h0009, 16'h1140, 16'h1111, 16'h2222, 16'h0000, 9, 0, 1);
    run("reset timeout", 0);
    // R2 R4 R9: last address, control all-ones is still valid, reset clears on last poll
    setup(31, 16'hFFFF, 16'h0000, 16'h0100, 16'h0141, 16'h0C54, 16'h01E1, PM - 1, 0, 4);
    run("find at 31", 0);
    // R5: reset write reports an error
    setup(7, 16'h1140, 16'h7849, 16'h1140, 16'h0001, 16'h0002, 16'h0001, 0, 1, 3);
    run("reset write error", 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule